// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block holds the four-state coherence tag (Modified, Exclusive, Shared, Invalid) for every line of a small private cache on a shared snooping bus. It sits between the processor-side lookup logic and the bus. The lookup logic already knows whether an access hit and whether the line being replaced is dirty. The controller decides which bus transactions are needed, in what order, and what each line's state becomes afterwards. The data arrays, the tag compare and arbitration stay outside. The tag-match result for a snooped address arrives as an input.

The processor presents one request for one cycle while the controller is idle. The controller then holds `bus_req` with an operation code and line index until the bus answers with `bus_gnt`. A grant cycle completes that transaction. The `bus_shared` line is sampled in the same grant cycle. When the whole access is finished, `req_done` pulses for one cycle. Transactions from other caches appear on the snoop inputs, and the controller answers them combinationally in the same cycle. It asserts `snp_shared` when it keeps a copy and `snp_flush` when it must supply dirty data. The line's new state is registered at the next clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After a synchronous reset every line is Invalid: a snooped read that hits any index gets neither `snp_shared` nor `snp_flush`, and `bus_req` and `req_done` are low.
- R2: A read miss puts op code 0 (read) on the bus. The line is installed Exclusive if `bus_shared` is low in the grant cycle and Shared if it is high. `req_done` follows one cycle after the grant.
- R3: A write miss puts op code 1 (read-for-ownership) on the bus and installs the line as Modified.
- R4: A write hit on an Exclusive line makes it Modified with no bus request, and `req_done` rises in the cycle after acceptance.
- R5: A write hit on a Shared line puts op code 2 (invalidate) on the bus and makes the line Modified when the grant arrives.
- R6: A miss flagged with a dirty victim first issues op code 3 (write-back) for the same index. It then issues the read or read-for-ownership for that index, with `bus_req` held high between them.
- R7: A snooped read (op 0) that hits a Modified line asserts both `snp_flush` and `snp_shared`, and the line becomes Shared.
- R8: A snooped read-for-ownership (op 1) that hits a Modified line asserts `snp_flush` without `snp_shared`, and the line becomes Invalid.
- R9: A snooped read that hits an Exclusive or Shared line asserts `snp_shared` only and leaves the line Shared. A snooped read-for-ownership on such a line asserts nothing and leaves it Invalid.
- R10: A snooped invalidate (op 2) that hits a valid line asserts nothing and leaves the line Invalid.
- R11: Read hits in any valid state and write hits in Modified keep the state and make no bus request. `req_done` comes one cycle after acceptance.
- R12: If a pending, not yet granted invalidate loses its line to a snooped read-for-ownership or invalidate, the request turns into a read-for-ownership (op 1) for the same index. The line still ends Modified.
- R13: A snoop with `snp_hit` low, or to an Invalid line, produces no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access offered (taken while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Line index of the access |
| req_hit | input | 1 | Tag lookup matched |
| req_victim_dirty | input | 1 | Line being replaced holds dirty data |
| req_done | output | 1 | One-cycle pulse when the access completes |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_idx | output | IDX_W | Line index of the transaction |
| bus_gnt | input | 1 | Grant; a grant cycle completes the transaction |
| bus_shared | input | 1 | Another cache keeps a copy (sampled at grant) |
| snp_valid | input | 1 | Another cache's transaction on the bus |
| snp_op | input | 2 | Op code of the snooped transaction |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_hit | input | 1 | Snooped address matches the stored tag |
| snp_shared | output | 1 | This cache keeps a copy |
| snp_flush | output | 1 | This cache supplies dirty data |

## Verification
A line held in the wrong state shows up at the ports the next time that line is touched. A snooped read shows it at once through the `snp_shared`/`snp_flush` pair, which tells Invalid, clean and Modified apart. A write hit shows it within one cycle by whether `bus_req` rises with an invalidate, which tells Exclusive from Shared. The stimulus therefore follows every state change with one of these probes. Ordering faults, such as a missing write-back or a wrong op code after a lost upgrade, show on `bus_op` in the first cycle of each request.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_RDX = 2'd1,
    OP_INV = 2'd2,
    OP_WB  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_e         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_e         rd_b_st,
  // port A has priority when both write one line
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  line_st_e         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_e         wb_st
);
  line_st_e lines [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        lines[g] <= ST_I;
      else if (wa_en && wa_idx == IDX_W'(g))
        lines[g] <= wa_st;
      else if (wb_en && wb_idx == IDX_W'(g))
        lines[g] <= wb_st;
    end
  end

  assign rd_a_st = lines[rd_a_idx];
  assign rd_b_st = lines[rd_b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
(
  input  logic     snp_valid,
  input  bus_op_e  snp_op,
  input  logic     snp_hit,
  input  line_st_e cur_st,
  output logic     shared_o,
  output logic     flush_o,
  output logic     we_o,
  output line_st_e nxt_o
);
  always_comb begin
    shared_o = 1'b0;
    flush_o  = 1'b0;
    we_o     = 1'b0;
    nxt_o    = cur_st;
    if (snp_valid && snp_hit && cur_st != ST_I) begin
      unique case (snp_op)
        OP_RD: begin
          shared_o = 1'b1;
          flush_o  = (cur_st == ST_M);
          we_o     = 1'b1;
          nxt_o    = ST_S;
        end
        OP_RDX: begin
          flush_o = (cur_st == ST_M);
          we_o    = 1'b1;
          nxt_o   = ST_I;
        end
        OP_INV: begin
          we_o  = 1'b1;
          nxt_o = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_hit,
  input  logic             req_victim_dirty,
  input  line_st_e         cur_st,
  input  logic             bus_gnt,
  input  logic             bus_shared,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_idx,
  input  line_st_e         snp_nxt,
  output logic             req_done,
  output logic             bus_req,
  output bus_op_e          bus_op,
  output logic [IDX_W-1:0] bus_idx,
  output logic             own_we,
  output logic [IDX_W-1:0] own_idx,
  output line_st_e         own_st
);
  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_UPG} fsm_e;

  fsm_e fsm;
  logic pend_wr;
  logic take, hit_ok, lost;

  assign take   = (fsm == F_IDLE) && req_valid;
  assign hit_ok = req_hit && (cur_st != ST_I);
  assign lost   = snp_we && (snp_idx == bus_idx) && (snp_nxt == ST_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm      <= F_IDLE;
      pend_wr  <= 1'b0;
      req_done <= 1'b0;
      bus_req  <= 1'b0;
      bus_op   <= OP_RD;
      bus_idx  <= '0;
    end else begin
      req_done <= 1'b0;
      unique case (fsm)
        F_IDLE: if (take) begin
          bus_idx <= req_idx;
          pend_wr <= req_write;
          if (hit_ok) begin
            if (req_write && cur_st == ST_S) begin
              bus_op  <= OP_INV;
              bus_req <= 1'b1;
              fsm     <= F_UPG;
            end else begin
              req_done <= 1'b1;
            end
          end else if (req_victim_dirty) begin
            bus_op  <= OP_WB;
            bus_req <= 1'b1;
            fsm     <= F_WB;
          end else begin
            bus_op  <= req_write ? OP_RDX : OP_RD;
            bus_req <= 1'b1;
            fsm     <= F_FILL;
          end
        end
        F_WB: if (bus_gnt) begin
          bus_op <= pend_wr ? OP_RDX : OP_RD;
          fsm    <= F_FILL;
        end
        F_FILL, F_UPG: begin
          if (bus_gnt) begin
            bus_req  <= 1'b0;
            req_done <= 1'b1;
            fsm      <= F_IDLE;
          end else if (fsm == F_UPG && lost) begin
            bus_op <= OP_RDX;
            fsm    <= F_FILL;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    own_we  = 1'b0;
    own_idx = bus_idx;
    own_st  = ST_M;
    unique case (fsm)
      F_IDLE: begin
        own_idx = req_idx;
        own_we  = take && hit_ok && req_write && cur_st == ST_E;
      end
      F_WB: begin
        own_we = bus_gnt;
        own_st = ST_I;
      end
      F_FILL: begin
        own_we = bus_gnt;
        own_st = pend_wr ? ST_M : (bus_shared ? ST_S : ST_E);
      end
      F_UPG: own_we = bus_gnt;
      default: ;
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_hit,
  input  logic             req_victim_dirty,
  output logic             req_done,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_gnt,
  input  logic             bus_shared,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             snp_hit,
  output logic             snp_shared,
  output logic             snp_flush
);
  line_st_e         req_st, snp_st, own_st, snp_nxt;
  logic             own_we, snp_we;
  logic [IDX_W-1:0] own_idx;
  bus_op_e          op_q;

  mesi_state_array #(.LINES(LINES)) u_arr (
    .clk(clk), .rst(rst),
    .rd_a_idx(req_idx), .rd_a_st(req_st),
    .rd_b_idx(snp_idx), .rd_b_st(snp_st),
    .wa_en(own_we), .wa_idx(own_idx), .wa_st(own_st),
    .wb_en(snp_we), .wb_idx(snp_idx), .wb_st(snp_nxt)
  );

  mesi_snoop_resp u_snp (
    .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_op)), .snp_hit(snp_hit),
    .cur_st(snp_st), .shared_o(snp_shared), .flush_o(snp_flush),
    .we_o(snp_we), .nxt_o(snp_nxt)
  );

  mesi_req_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_idx(req_idx),
    .req_hit(req_hit), .req_victim_dirty(req_victim_dirty), .cur_st(req_st),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared),
    .snp_we(snp_we), .snp_idx(snp_idx), .snp_nxt(snp_nxt),
    .req_done(req_done), .bus_req(bus_req), .bus_op(op_q), .bus_idx(bus_idx),
    .own_we(own_we), .own_idx(own_idx), .own_st(own_st)
  );

  assign bus_op = op_q;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_done,
  input logic             bus_req,
  input logic [1:0]       bus_op,
  input logic [IDX_W-1:0] bus_idx,
  input logic             bus_gnt,
  input logic             snp_valid,
  input logic [1:0]       snp_op,
  input logic             snp_hit,
  input logic             snp_shared,
  input logic             snp_flush
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_req && !req_done));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_op == 2'd3) |=>
      (bus_req && (bus_op == 2'd0 || bus_op == 2'd1) && $stable(bus_idx)));

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_idx)));

  // R5
  done_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt && bus_op != 2'd3) |=> (req_done && !bus_req));

  // R13
  no_resp_unhit_chk: assert property (@(posedge clk) disable iff (rst)
    (!snp_valid || !snp_hit) |-> (!snp_shared && !snp_flush));

  // R8
  rdx_no_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == 2'd1) |-> !snp_shared);

  // R10
  inv_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == 2'd2) |-> (!snp_shared && !snp_flush));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_done(req_done), .bus_req(bus_req),
  .bus_op(bus_op), .bus_idx(bus_idx), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_op(snp_op), .snp_hit(snp_hit),
  .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
  localparam int LINES = 16;
  localparam logic [2:0] NO = 3'd4;
  localparam logic [2:0] RD = 3'd0, RX = 3'd1, IV = 3'd2, WB = 3'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_hit = 0, req_victim_dirty = 0;
  logic [3:0] req_idx = '0;
  logic req_done, bus_req;
  logic [1:0] bus_op;
  logic [3:0] bus_idx;
  logic bus_gnt = 0, bus_shared = 0;
  logic snp_valid = 0, snp_hit = 0;
  logic [1:0] snp_op = '0;
  logic [3:0] snp_idx = '0;
  logic snp_shared, snp_flush;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) u_mesi_line_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_hit(req_hit), .req_victim_dirty(req_victim_dirty),
    .req_done(req_done), .bus_req(bus_req), .bus_op(bus_op), .bus_idx(bus_idx),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared), .snp_valid(snp_valid),
    .snp_op(snp_op), .snp_idx(snp_idx), .snp_hit(snp_hit),
    .snp_shared(snp_shared), .snp_flush(snp_flush)
  );

  typedef struct packed {
    logic       snp;
    logic [1:0] sop;
    logic       wr;
    logic [3:0] idx;
    logic       hit;
    logic       vd;
    logic       sh;
    logic [2:0] e1;
    logic [2:0] e2;
    logic [3:0] rq;
  } vec_t;

  // proc rows: e1/e2 = expected bus ops; snoop rows: e1 = {0, shared, flush}
  localparam vec_t VECS [24] = '{
    '{0, 2'd0, 0, 4'd1, 0, 0, 0, RD, NO, 4'd2},      // R2 read miss, alone -> E
    '{0, 2'd0, 1, 4'd1, 1, 0, 0, NO, NO, 4'd4},      // R4 E write hit silent
    '{0, 2'd0, 0, 4'd1, 1, 0, 0, NO, NO, 4'd11},     // R11 M read hit
    '{1, 2'd0, 0, 4'd1, 1, 0, 0, 3'b011, NO, 4'd7},  // R7 M snooped read
    '{0, 2'd0, 1, 4'd1, 1, 0, 0, IV, NO, 4'd5},      // R5 S write hit
    '{1, 2'd1, 0, 4'd1, 1, 0, 0, 3'b001, NO, 4'd8},  // R8 M snooped rfo
    '{1, 2'd0, 0, 4'd1, 1, 0, 0, 3'b000, NO, 4'd8},  // R8 line now I
    '{0, 2'd0, 0, 4'd2, 0, 0, 1, RD, NO, 4'd2},      // R2 read miss, shared -> S
    '{1, 2'd0, 0, 4'd2, 1, 0, 0, 3'b010, NO, 4'd9},  // R9 S snooped read
    '{0, 2'd0, 1, 4'd2, 1, 0, 0, IV, NO, 4'd5},      // R5 still S
    '{0, 2'd0, 1, 4'd3, 0, 0, 0, RX, NO, 4'd3},      // R3 write miss
    '{0, 2'd0, 1, 4'd3, 1, 0, 0, NO, NO, 4'd11},     // R11 M write hit
    '{0, 2'd0, 0, 4'd3, 0, 1, 0, WB, RD, 4'd6},      // R6 dirty victim, read
    '{1, 2'd1, 0, 4'd3, 1, 0, 0, 3'b000, NO, 4'd9},  // R9 E snooped rfo
    '{1, 2'd0, 0, 4'd3, 1, 0, 0, 3'b000, NO, 4'd9},  // R9 line now I
    '{0, 2'd0, 1, 4'd4, 0, 1, 0, WB, RX, 4'd6},      // R6 dirty victim, write
    '{1, 2'd0, 0, 4'd4, 0, 0, 0, 3'b000, NO, 4'd13}, // R13 tag miss ignored
    '{1, 2'd0, 0, 4'd4, 1, 0, 0, 3'b011, NO, 4'd13}, // R13 still M
    '{1, 2'd2, 0, 4'd4, 1, 0, 0, 3'b000, NO, 4'd10}, // R10 snooped invalidate
    '{1, 2'd0, 0, 4'd4, 1, 0, 0, 3'b000, NO, 4'd10}, // R10 line now I
    '{0, 2'd0, 0, 4'd5, 0, 0, 0, RD, NO, 4'd2},      // R2 -> E
    '{1, 2'd0, 0, 4'd5, 1, 0, 0, 3'b010, NO, 4'd9},  // R9 E snooped read
    '{0, 2'd0, 0, 4'd5, 1, 0, 0, NO, NO, 4'd11},     // R11 S read hit
    '{1, 2'd0, 0, 4'd5, 1, 0, 0, 3'b010, NO, 4'd11}  // R11 still S
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic proc(input logic wr, input logic [3:0] idx, input logic hit,
                      input logic vd, input logic sh,
                      output logic [2:0] op1, output logic [2:0] op2);
    op1 = NO;
    op2 = NO;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_idx = idx; req_hit = hit;
    req_victim_dirty = vd;
    @(negedge clk);
    req_valid = 0;
    for (int n = 0; n < 20 && !req_done; n++) begin
      if (bus_req) begin
        if (op1 == NO) op1 = {1'b0, bus_op};
        else op2 = {1'b0, bus_op};
        bus_gnt = 1; bus_shared = sh;
      end
      @(negedge clk);
      bus_gnt = 0; bus_shared = 0;
    end
  endtask

  task automatic snoop(input logic [1:0] op, input logic [3:0] idx,
                       input logic hit, output logic [2:0] resp);
    @(negedge clk);
    snp_valid = 1; snp_op = op; snp_idx = idx; snp_hit = hit;
    #1 resp = {1'b0, snp_shared, snp_flush};
    @(negedge clk);
    snp_valid = 0; snp_hit = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [2:0] a, b;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(!bus_req && !req_done, "R1 outputs", {bus_req, req_done}, 0);
    snoop(2'd0, 4'd0, 1, a);
    chk(a == 0, "R1 idx0", a, 0);
    snoop(2'd0, 4'd15, 1, a);
    chk(a == 0, "R1 idx15", a, 0);

    foreach (VECS[i]) begin
      if (VECS[i].snp) begin
        snoop(VECS[i].sop, VECS[i].idx, VECS[i].hit, a);
        chk(a == VECS[i].e1, $sformatf("R%0d row%0d snoop", VECS[i].rq, i),
            a, VECS[i].e1);
      end else begin
        proc(VECS[i].wr, VECS[i].idx, VECS[i].hit, VECS[i].vd, VECS[i].sh, a, b);
        chk({a, b} == {VECS[i].e1, VECS[i].e2},
            $sformatf("R%0d row%0d ops", VECS[i].rq, i),
            {a, b}, {VECS[i].e1, VECS[i].e2});
      end
    end

    // R12 lost upgrade turns into read-for-ownership
    proc(1'b0, 4'd6, 1'b0, 1'b0, 1'b1, a, b);           // line 6 -> S
    @(negedge clk);
    req_valid = 1; req_write = 1; req_idx = 4'd6; req_hit = 1; req_victim_dirty = 0;
    @(negedge clk);
    req_valid = 0;
    chk(bus_req && bus_op == 2'd2, "R12 first op invalidate", bus_op, 2);
    snp_valid = 1; snp_op = 2'd1; snp_idx = 4'd6; snp_hit = 1;
    #1 chk(!snp_flush && !snp_shared, "R12 snoop resp", {snp_shared, snp_flush}, 0);
    @(negedge clk);
    snp_valid = 0; snp_hit = 0;
    chk(bus_req && bus_op == 2'd1 && bus_idx == 4'd6, "R12 converted op", bus_op, 1);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(req_done && !bus_req, "R12 done", req_done, 1);
    snoop(2'd0, 4'd6, 1, a);
    chk(a == 3'b011, "R12 line Modified", a, 3);

    // R1 reset mid-run clears valid lines (2 is M, 5 is S)
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    snoop(2'd0, 4'd2, 1, a);
    chk(a == 0, "R1 idx2 after reset", a, 0);
    snoop(2'd0, 4'd5, 1, a);
    chk(a == 0, "R1 idx5 after reset", a, 0);
    finish_run();
  end
endmodule